// File: doc/BRIEF.md
# Flash Security Control Register Unit

This block is the small register file that a microcontroller core uses to steer flash programming and security fuse burning. The CPU reaches it through a plain register bus: a 2-bit address, a write enable, 8-bit write data and combinational read data. The block holds four registers: flash control, fuse select, trim/burn command and security.

From these registers it drives a handful of control outputs:
- a level that redirects external-data store moves into program flash;
- a one-shot mass-erase arm;
- a sticky read lock that bars outside access to flash and program RAM;
- a burn-active level for the fuse cells.

The flash array, the fuse cells and the CPU are outside the block. They appear only as a byte-written strobe, an erase-started strobe, the global interrupt enable level and the burn-active output. A security strap pin is synchronized into the block and can be read back.

Several bits guard themselves:
- The program-write enable clears after every flash byte and cannot be written while interrupts are enabled.
- The erase arm is consumed by each erase.
- The lock bit can only be set.
- Burning needs an exact command byte, combined with an exact fuse-select value and a permanent-programming enable.

Top module: `flash_sec_ctl`

## Requirements
- R1: After a synchronous active-low reset every register reads 0x00 and the outputs `xdata_to_flash`, `mass_erase_arm`, `read_lock` and `fuse_burn` are 0. The security pin bit reads 0 while the pin is low.
- R2: Address 0 selects flash control, 1 selects fuse select, 2 selects trim/burn command and 3 selects security. `bus_rdata` reflects the addressed register in the same cycle. The trim register reads back the last byte written to it, and unused flash control bits (5:2 and 7) read 0.
- R3: Flash control bit 0 is program-write enable. Writing it while `irq_glob_en` is 0 loads it on the next edge. `xdata_to_flash` equals this bit.
- R4: A `flash_byte_done` pulse clears program-write enable on the next edge. If a write that sets the bit arrives in the same cycle, the clear wins.
- R5: While `irq_glob_en` is 1, a flash control write leaves program-write enable unchanged, but bits 1 and 6 of the same write still take effect.
- R6: Flash control bit 1 is mass-erase enable and drives `mass_erase_arm`. An `erase_start` pulse clears it on the next edge, and in the same cycle it wins over a write.
- R7: Flash control bit 6 is the lock bit and drives `read_lock`. Writing 1 sets it, writing 0 leaves it set, and only reset clears it.
- R8: The fuse select register at address 1 is a full 8-bit read/write register.
- R9: Security bit 7 is the permanent-programming enable and is read/write.
- R10: `fuse_burn` is 1 exactly while all three conditions hold: the last trim write was 0xA6, fuse select holds 0x54, and the permanent-programming enable is 1. A trim write of any other value drops it on the next edge.
- R11: Security bit 5 shows the security pin through a two-flop synchronizer. A pin change becomes readable after the second rising edge. Writes to bit 5 and to bits 4:0 and 6 are ignored, and those other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| irq_glob_en | input | 1 | Global interrupt enable level from the core |
| flash_byte_done | input | 1 | One-cycle pulse: a flash byte was written |
| erase_start | input | 1 | One-cycle pulse: a mass erase began |
| sec_pin | input | 1 | Asynchronous security strap pin |
| xdata_to_flash | output | 1 | External-data stores go to program flash |
| mass_erase_arm | output | 1 | Mass erase is armed |
| read_lock | output | 1 | External flash/program RAM reads blocked |
| fuse_burn | output | 1 | Selected fuse is being burned |

## Verification
A software write to flash control can land in the same cycle as a hardware strobe that clears one of its bits. A write setting program-write enable can meet `flash_byte_done`, and a write setting mass-erase enable can meet `erase_start`. The bench provokes this by raising the write strobe and both pulses in one cycle. It then judges both the outputs and the read-back: the strobes must win and the lock bit from the same write must still stick. The burn command is likewise raced against changes to its qualifying registers, and the output must track the three-way condition at every step.

// File: rtl/fsc_pkg.sv
// Shared constants for the flash security control unit: register
// addresses, bit positions and command bytes. Assumes an 8-bit bus.
package fsc_pkg;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_FLASH = 2'd0;
    localparam logic [ADDR_W-1:0] A_FUSE  = 2'd1;
    localparam logic [ADDR_W-1:0] A_TRIM  = 2'd2;
    localparam logic [ADDR_W-1:0] A_SEC   = 2'd3;

    localparam int B_PWE  = 0;
    localparam int B_MEE  = 1;
    localparam int B_LOCK = 6;
    localparam int B_PIN  = 5;
    localparam int B_PERM = 7;

    localparam logic [DATA_W-1:0] CMD_BURN   = 8'hA6;
    localparam logic [DATA_W-1:0] FUSE_SECUR = 8'h54;
endpackage

// File: rtl/fsc_flash_reg.sv
// Flash control bits: program-write enable, mass-erase enable and the
// set-only lock. Assumes wr_en is already decoded for this register and
// that the strobes are one-cycle pulses synchronous to clk.
module fsc_flash_reg
    import fsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_en,
    input  logic              byte_done,
    input  logic              erase_go,
    output logic              pwe,
    output logic              mee,
    output logic              lock
);
    logic pwe_d, mee_d, lock_d;

    // Next state: hardware clears win over software writes.
    always_comb begin
        pwe_d  = pwe;
        mee_d  = mee;
        lock_d = lock;
        if (wr_en) begin
            if (!irq_en) pwe_d = wdata[B_PWE];
            mee_d  = wdata[B_MEE];
            lock_d = lock | wdata[B_LOCK];
        end
        if (byte_done) pwe_d = 1'b0;
        if (erase_go)  mee_d = 1'b0;
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwe  <= 1'b0;
            mee  <= 1'b0;
            lock <= 1'b0;
        end else begin
            pwe  <= pwe_d;
            mee  <= mee_d;
            lock <= lock_d;
        end
    end

    // R5
    pwe_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && irq_en && !byte_done) |=> (pwe == $past(pwe)));
    // R4
    pwe_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !pwe);
    // R6
    mee_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> !mee);
    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(lock));
endmodule

// File: rtl/fsc_fuse_ctl.sv
// Fuse select, trim/burn command and permanent-programming enable.
// The burn command arms on the exact command byte; the output is gated
// by the fuse select value and the enable. Assumes decoded write strobes.
module fsc_fuse_ctl
    import fsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fuse_wr,
    input  logic              trim_wr,
    input  logic              sec_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] fuse_val,
    output logic [DATA_W-1:0] trim_val,
    output logic              perm_en,
    output logic              burn
);
    logic armed;

    // Register file for the three software-visible fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fuse_val <= '0;
            trim_val <= '0;
            perm_en  <= 1'b0;
        end else begin
            if (fuse_wr) fuse_val <= wdata;
            if (trim_wr) trim_val <= wdata;
            if (sec_wr)  perm_en  <= wdata[B_PERM];
        end
    end

    // Burn arm: each trim write re-decides it from the command byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (trim_wr) armed <= (wdata == CMD_BURN);
    end

    // Burn output qualified by the selected fuse and the enable.
    always_comb burn = armed && (fuse_val == FUSE_SECUR) && perm_en;

    // R10
    burn_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burn |-> (trim_val == CMD_BURN));
    // R10
    burn_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_wr && wdata != CMD_BURN) |=> !burn);
endmodule

// File: rtl/fsc_pin_sync.sv
// Multi-flop synchronizer for the security strap pin. Assumes the pin
// is slow and quasi-static; STAGES must be at least 2.
module fsc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin_raw};
    end

    always_comb pin_sync = chain[STAGES-1];

    // R11
    sync_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain[1] == $past(chain[0]));
endmodule

// File: rtl/flash_sec_ctl.sv
// Top of the flash security control unit: decodes the register bus,
// instantiates the flash bits, the fuse control and the pin synchronizer
// and assembles read data. Assumes a single-cycle bus with no wait states.
module flash_sec_ctl
    import fsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_glob_en,
    input  logic              flash_byte_done,
    input  logic              erase_start,
    input  logic              sec_pin,
    output logic              xdata_to_flash,
    output logic              mass_erase_arm,
    output logic              read_lock,
    output logic              fuse_burn
);
    localparam int NREG = 1 << ADDR_W;

    logic [NREG-1:0]   wr_sel;
    logic              pwe, mee, lock, perm_en, pin_s;
    logic [DATA_W-1:0] fuse_val, trim_val;
    logic [DATA_W-1:0] flash_rd, sec_rd;

    // One write strobe per register.
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign wr_sel[g] = bus_we && (bus_addr == ADDR_W'(g));
    end

    fsc_flash_reg i_flash (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_sel[A_FLASH]),
        .wdata    (bus_wdata),
        .irq_en   (irq_glob_en),
        .byte_done(flash_byte_done),
        .erase_go (erase_start),
        .pwe      (pwe),
        .mee      (mee),
        .lock     (lock)
    );

    fsc_fuse_ctl i_fuse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fuse_wr (wr_sel[A_FUSE]),
        .trim_wr (wr_sel[A_TRIM]),
        .sec_wr  (wr_sel[A_SEC]),
        .wdata   (bus_wdata),
        .fuse_val(fuse_val),
        .trim_val(trim_val),
        .perm_en (perm_en),
        .burn    (fuse_burn)
    );

    fsc_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (sec_pin),
        .pin_sync(pin_s)
    );

    // Assemble sparse read words.
    always_comb begin
        flash_rd         = '0;
        flash_rd[B_PWE]  = pwe;
        flash_rd[B_MEE]  = mee;
        flash_rd[B_LOCK] = lock;
        sec_rd           = '0;
        sec_rd[B_PERM]   = perm_en;
        sec_rd[B_PIN]    = pin_s;
    end

    // Read multiplexer.
    always_comb begin
        unique case (bus_addr)
            A_FLASH: bus_rdata = flash_rd;
            A_FUSE:  bus_rdata = fuse_val;
            A_TRIM:  bus_rdata = trim_val;
            default: bus_rdata = sec_rd;
        endcase
    end

    assign xdata_to_flash = pwe;
    assign mass_erase_arm = mee;
    assign read_lock      = lock;

    // R10
    burn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_burn |-> (fuse_val == FUSE_SECUR && perm_en));
endmodule

// File: tb/test_flash_sec_ctl.sv
module test_flash_sec_ctl;
    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        int          sel;   // 0 rdata, 1 xdata, 2 erase, 3 lock, 4 burn
        logic [7:0]  exp;
        string       tag;
    } item_t;

    logic       clk = 0, rst_n = 0;
    logic [1:0] bus_addr = 0;
    logic       bus_we = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic       irq_glob_en = 0, flash_byte_done = 0, erase_start = 0, sec_pin = 0;
    logic       xdata_to_flash, mass_erase_arm, read_lock, fuse_burn;
    int         checks = 0, errors = 0;
    bit         done = 0;
    item_t      sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_sec_ctl i_flash_sec_ctl (.*);

    // Driver side: queue expectations.
    task automatic exp_out(int sel, logic [7:0] exp, string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic exp_reg(logic [1:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 0;
        exp_out(0, exp, tag);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    // Monitor: pop and compare away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                case (it.sel)
                    0: act = bus_rdata;
                    1: act = {7'd0, xdata_to_flash};
                    2: act = {7'd0, mass_erase_arm};
                    3: act = {7'd0, read_lock};
                    default: act = {7'd0, fuse_burn};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state, R2 map
        for (int a = 0; a < 4; a++) exp_reg(2'(a), 8'h00, "R1 reset read");
        exp_out(1, 0, "R1 xdata"); exp_out(2, 0, "R1 erase");
        exp_out(3, 0, "R1 lock");  exp_out(4, 0, "R1 burn");
        // R8 fuse select, R2 trim readback
        wr(1, 8'h5A); exp_reg(1, 8'h5A, "R8 fuse rw");
        wr(2, 8'h3C); exp_reg(2, 8'h3C, "R2 trim readback");
        // R3 program-write enable
        wr(0, 8'h01); exp_out(1, 1, "R3 pwe set");
        exp_reg(0, 8'h01, "R3 pwe read");
        // R4 self clear
        @(negedge clk); flash_byte_done = 1;
        @(negedge clk); flash_byte_done = 0;
        exp_out(1, 0, "R4 pwe cleared");
        // R5 irq block, other bits still land
        irq_glob_en = 1;
        wr(0, 8'h43);
        exp_out(1, 0, "R5 pwe blocked");
        exp_out(2, 1, "R5 mee lands");
        exp_out(3, 1, "R5 lock lands");
        exp_reg(0, 8'h42, "R5 read");
        irq_glob_en = 0;
        // R7 lock cannot be cleared
        wr(0, 8'h00);
        exp_out(3, 1, "R7 lock sticky");
        exp_reg(0, 8'h40, "R7 read");
        // R6 erase consumes arm
        wr(0, 8'h02); exp_out(2, 1, "R6 arm");
        @(negedge clk); erase_start = 1;
        @(negedge clk); erase_start = 0;
        exp_out(2, 0, "R6 consumed");
        // R4/R6 race: write vs strobes in one cycle
        @(negedge clk);
        bus_addr = 0; bus_we = 1; bus_wdata = 8'h03;
        flash_byte_done = 1; erase_start = 1;
        @(negedge clk);
        bus_we = 0; flash_byte_done = 0; erase_start = 0;
        exp_out(1, 0, "R4 race clear wins");
        exp_out(2, 0, "R6 race clear wins");
        exp_reg(0, 8'h40, "R4 R6 race read");
        // R9 / R11 security register
        wr(3, 8'hFF); exp_reg(3, 8'h80, "R9 R11 sec bits");
        // R10 burn qualification
        wr(2, 8'hA6); exp_out(4, 0, "R10 fuse not selected");
        wr(1, 8'h54); exp_out(4, 1, "R10 burn on");
        wr(3, 8'h00); exp_out(4, 0, "R10 perm off");
        wr(3, 8'h80); exp_out(4, 1, "R10 perm back");
        wr(2, 8'h00); exp_out(4, 0, "R10 stop by other value");
        wr(2, 8'hA6); exp_out(4, 1, "R10 rearm");
        wr(2, 8'hA7); exp_out(4, 0, "R10 near value stops");
        // R11 synchronizer latency
        @(negedge clk); bus_addr = 3; sec_pin = 1;
        exp_reg(3, 8'h80, "R11 one edge");
        exp_reg(3, 8'hA0, "R11 two edges");
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule